// File: doc/BRIEF.md
# Operand Forwarding Selector with Load-Use Flag

This block sits beside the execute stage of a five-stage integer pipeline. For the instruction currently in execute it picks, separately for each of the two source operands, where the operand value should come from. There are three choices: the value read from the register file during decode, the result held by the instruction now in the memory stage, or the result held by the instruction now in write-back. The block drives the select inputs of the operand multiplexers in front of the ALU. It does not touch the data values.

Alongside the two selects the block raises a load-use flag. The flag is set when the instruction one stage ahead is a load whose destination the execute instruction names as a source. A stall or bubble controller elsewhere in the pipeline consumes this flag. The block itself never stalls or flushes anything.

The source fields of the execute instruction are compared without decoding its format. An instruction that does not read a register, such as an unconditional jump, still gets selects computed from whatever bits occupy its source fields. The block holds no state. Every output is a function of the stage fields presented in the same cycle.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Each operand select uses 2'b00 for the decode-stage register value, 2'b01 for the memory-stage result and 2'b10 for the write-back result. The value 2'b11 never appears.
- R2: An operand selects the memory-stage result (2'b01) when the memory-stage instruction writes a register, its destination is nonzero, and that destination equals the operand's source field.
- R3: An operand selects the write-back result (2'b10) when the write-back instruction writes a register, its destination is nonzero and equals the source field, and the memory stage does not qualify under R2 for that operand.
- R4: When both the memory stage and the write-back stage qualify for the same operand, the memory-stage result (2'b01) is chosen.
- R5: A source field of register 0 always yields 2'b00, even when a writing stage has destination 0.
- R6: A stage whose register-write flag is clear never supplies a forwarded value, whatever its destination and other flags.
- R7: The execute instruction's own flags (jump, branch, memory write, load, register write) and its destination field have no effect on the selects or the load-use flag. Only its two source fields matter.
- R8: The load-use flag is 1 when the memory-stage instruction has both its load flag and its register-write flag set, its destination is nonzero, and that destination equals either execute source field.
- R9: The load-use flag is 0 when the memory-stage load flag or register-write flag is clear, or when its destination is 0. A load in the write-back stage never raises it.
- R10: All outputs follow the inputs combinationally within the same cycle, with no clock and no retained state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exRs1 | input | REG_IDX_W | Execute-stage first source field |
| exRs2 | input | REG_IDX_W | Execute-stage second source field |
| exRd | input | REG_IDX_W | Execute-stage destination field (not used for selection) |
| exMemToReg | input | 1 | Execute-stage load flag (not used for selection) |
| exRegWrite | input | 1 | Execute-stage register-write flag (not used for selection) |
| exMemWrite | input | 1 | Execute-stage store flag (not used for selection) |
| exBranch | input | 1 | Execute-stage branch flag (not used for selection) |
| exJump | input | 1 | Execute-stage jump flag (not used for selection) |
| memRs1 | input | REG_IDX_W | Memory-stage first source field (not used) |
| memRs2 | input | REG_IDX_W | Memory-stage second source field (not used) |
| memRd | input | REG_IDX_W | Memory-stage destination field |
| memMemToReg | input | 1 | Memory-stage load flag |
| memRegWrite | input | 1 | Memory-stage register-write flag |
| memMemWrite | input | 1 | Memory-stage store flag (not used) |
| memBranch | input | 1 | Memory-stage branch flag (not used) |
| memJump | input | 1 | Memory-stage jump flag (not used) |
| wbRs1 | input | REG_IDX_W | Write-back first source field (not used) |
| wbRs2 | input | REG_IDX_W | Write-back second source field (not used) |
| wbRd | input | REG_IDX_W | Write-back destination field |
| wbMemToReg | input | 1 | Write-back load flag (not used) |
| wbRegWrite | input | 1 | Write-back register-write flag |
| wbMemWrite | input | 1 | Write-back store flag (not used) |
| wbBranch | input | 1 | Write-back branch flag (not used) |
| wbJump | input | 1 | Write-back jump flag (not used) |
| fwdSelA | output | 2 | Select for the first operand |
| fwdSelB | output | 2 | Select for the second operand |
| loadHazard | output | 1 | Load-use flag |

## Verification
On every evaluation the embedded assertions confirm several things: no select carries the unused code, a zero source field never forwards, a qualifying memory-stage match wins over write-back, a lone write-back match selects write-back, and a raised load-use flag always agrees with a memory-stage select on some operand. The bench's directed scenarios are the only place some properties can be shown. These include the indifference to the execute instruction's own flags, where the same source fields are replayed under different flag settings; the silence of the flag for loads sitting in write-back; and the same-cycle settling of outputs between clock edges. A long randomized sweep over a narrow register range forces frequent matches and compares every cycle against the bench's behavioural model.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;

  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    SEL_DECODE = 2'b00,
    SEL_MEM    = 2'b01,
    SEL_WB     = 2'b10
  } fwdSel_e;

  // strobes from the comparator datapath to the select control
  typedef struct packed {
    logic [NUM_OPS-1:0] memHit;   // memory-stage destination matches operand
    logic [NUM_OPS-1:0] wbHit;    // write-back destination matches operand
    logic               memLoad;  // memory-stage instruction is a qualifying load
  } hitStrobes_t;

endpackage

// File: rtl/fwd_hazard_match.sv
module fwd_hazard_match
  import fwd_hazard_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [NUM_OPS-1:0][REG_IDX_W-1:0] exSrc,
  input  logic [REG_IDX_W-1:0]              memRd,
  input  logic                              memRegWrite,
  input  logic                              memMemToReg,
  input  logic [REG_IDX_W-1:0]              wbRd,
  input  logic                              wbRegWrite,
  output hitStrobes_t                       strobes
);

  localparam logic [REG_IDX_W-1:0] ZERO_REG = '0;

  logic memWrites;
  logic wbWrites;

  // a stage is a source only if it writes a register other than zero
  assign memWrites = memRegWrite && (memRd != ZERO_REG);
  assign wbWrites  = wbRegWrite  && (wbRd  != ZERO_REG);

  genvar op;
  generate
    for (op = 0; op < NUM_OPS; op++) begin : g_cmp
      assign strobes.memHit[op] = memWrites && (exSrc[op] == memRd);
      assign strobes.wbHit[op]  = wbWrites  && (exSrc[op] == wbRd);
    end
  endgenerate

  assign strobes.memLoad = memWrites && memMemToReg;

endmodule

// File: rtl/fwd_hazard_select.sv
module fwd_hazard_select
  import fwd_hazard_pkg::*;
(
  input  hitStrobes_t             strobes,
  output logic [NUM_OPS-1:0][1:0] selBus,
  output logic                    loadHazard
);

  genvar op;
  generate
    for (op = 0; op < NUM_OPS; op++) begin : g_pick
      fwdSel_e pick;
      always_comb begin
        // the nearer stage holds the younger value and takes priority
        if (strobes.memHit[op])     pick = SEL_MEM;
        else if (strobes.wbHit[op]) pick = SEL_WB;
        else                        pick = SEL_DECODE;
      end
      assign selBus[op] = pick;
    end
  endgenerate

  assign loadHazard = strobes.memLoad && (|strobes.memHit);

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_hazard_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] exRs1,
  input  logic [REG_IDX_W-1:0] exRs2,
  input  logic [REG_IDX_W-1:0] exRd,
  input  logic                 exMemToReg,
  input  logic                 exRegWrite,
  input  logic                 exMemWrite,
  input  logic                 exBranch,
  input  logic                 exJump,
  input  logic [REG_IDX_W-1:0] memRs1,
  input  logic [REG_IDX_W-1:0] memRs2,
  input  logic [REG_IDX_W-1:0] memRd,
  input  logic                 memMemToReg,
  input  logic                 memRegWrite,
  input  logic                 memMemWrite,
  input  logic                 memBranch,
  input  logic                 memJump,
  input  logic [REG_IDX_W-1:0] wbRs1,
  input  logic [REG_IDX_W-1:0] wbRs2,
  input  logic [REG_IDX_W-1:0] wbRd,
  input  logic                 wbMemToReg,
  input  logic                 wbRegWrite,
  input  logic                 wbMemWrite,
  input  logic                 wbBranch,
  input  logic                 wbJump,
  output logic [1:0]           fwdSelA,
  output logic [1:0]           fwdSelB,
  output logic                 loadHazard
);

  localparam logic [REG_IDX_W-1:0] ZERO_REG = '0;

  logic [NUM_OPS-1:0][REG_IDX_W-1:0] exSrc;
  logic [NUM_OPS-1:0][1:0]           selBus;
  hitStrobes_t                       strobes;
  logic [5*REG_IDX_W+11:0]           passiveFields;

  assign exSrc[0] = exRs1;
  assign exSrc[1] = exRs2;

  fwd_hazard_match #(.REG_IDX_W(REG_IDX_W)) u_match (
    .exSrc       (exSrc),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .memMemToReg (memMemToReg),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .strobes     (strobes)
  );

  fwd_hazard_select u_select (
    .strobes    (strobes),
    .selBus     (selBus),
    .loadHazard (loadHazard)
  );

  assign fwdSelA = selBus[0];
  assign fwdSelB = selBus[1];

  // fields carried along the pipeline that take no part in the decision
  assign passiveFields = {exRd, exMemToReg, exRegWrite, exMemWrite, exBranch, exJump,
                          memRs1, memRs2, memMemWrite, memBranch, memJump,
                          wbRs1, wbRs2, wbMemToReg, wbMemWrite, wbBranch, wbJump};

  // port-level checks across the comparator and the select control
  always_comb begin
    a_r10_known_inputs: assert (!$isunknown(passiveFields))
      else $error("R10: passive pipeline fields carry unknown bits");
    a_r1_no_unused_code: assert (fwdSelA != 2'b11 && fwdSelB != 2'b11)
      else $error("R1: select carries unused code");
    a_r5_zero_source_a: assert (exRs1 != ZERO_REG || fwdSelA == 2'b00)
      else $error("R5: zero source on operand A forwarded");
    a_r5_zero_source_b: assert (exRs2 != ZERO_REG || fwdSelB == 2'b00)
      else $error("R5: zero source on operand B forwarded");
    a_r4_mem_first_a: assert (!(memRegWrite && memRd != ZERO_REG && memRd == exRs1)
                              || fwdSelA == 2'b01)
      else $error("R4: memory-stage match on operand A not selected");
    a_r4_mem_first_b: assert (!(memRegWrite && memRd != ZERO_REG && memRd == exRs2)
                              || fwdSelB == 2'b01)
      else $error("R4: memory-stage match on operand B not selected");
    a_r3_wb_only_a: assert (!(wbRegWrite && wbRd != ZERO_REG && wbRd == exRs1
                              && !(memRegWrite && memRd == exRs1)) || fwdSelA == 2'b10)
      else $error("R3: lone write-back match on operand A not selected");
    a_r8_flag_agrees: assert (!loadHazard || fwdSelA == 2'b01 || fwdSelB == 2'b01)
      else $error("R8: load-use flag without memory-stage select");
    a_r9_flag_needs_load: assert (!loadHazard || (memMemToReg && memRegWrite))
      else $error("R9: load-use flag without a memory-stage load");
  end

endmodule

// File: tb/fwd_hazard_unit_bench.sv
module fwd_hazard_unit_bench;

  localparam int W = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [W-1:0] exRs1, exRs2, exRd, memRs1, memRs2, memRd, wbRs1, wbRs2, wbRd;
  logic exMemToReg, exRegWrite, exMemWrite, exBranch, exJump;
  logic memMemToReg, memRegWrite, memMemWrite, memBranch, memJump;
  logic wbMemToReg, wbRegWrite, wbMemWrite, wbBranch, wbJump;
  logic [1:0] fwdSelA, fwdSelB;
  logic loadHazard;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  fwd_hazard_unit #(.REG_IDX_W(W)) u_fwd_hazard_unit (.*);

  // behavioural reference
  function automatic int refSel(int src);
    if (src != 0 && memRegWrite && int'(memRd) == src) return 1;
    if (src != 0 && wbRegWrite && int'(wbRd) == src) return 2;
    return 0;
  endfunction

  function automatic bit refLoad();
    if (!memMemToReg || !memRegWrite || memRd == 0) return 0;
    return (memRd == exRs1) || (memRd == exRs2);
  endfunction

  task automatic compareNow(string tag);
    int expA, expB;
    bit expL;
    expA = refSel(int'(exRs1));
    expB = refSel(int'(exRs2));
    expL = refLoad();
    compared++;
    if (int'(fwdSelA) != expA || int'(fwdSelB) != expB || loadHazard != expL) begin
      mismatched++;
      $display("FAIL %s: selA=%0d selB=%0d hazard=%0b expected selA=%0d selB=%0d hazard=%0b",
               tag, fwdSelA, fwdSelB, loadHazard, expA, expB, expL);
    end
  endtask

  task automatic checkAtNeg(string tag);
    @(negedge clk);
    compareNow(tag);
  endtask

  task automatic clearAll();
    {exRs1, exRs2, exRd, memRs1, memRs2, memRd, wbRs1, wbRs2, wbRd} = '0;
    {exMemToReg, exRegWrite, exMemWrite, exBranch, exJump} = '0;
    {memMemToReg, memRegWrite, memMemWrite, memBranch, memJump} = '0;
    {wbMemToReg, wbRegWrite, wbMemWrite, wbBranch, wbJump} = '0;
  endtask

  task automatic nextCycle();
    @(posedge clk);
    #1;
    clearAll();
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    clearAll();
    // reset state: all-zero fields give decode selects and no flag (R1)
    checkAtNeg("R1 reset");
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    // R2: memory-stage writer matches operand A
    nextCycle(); memRegWrite = 1; memRd = 6; exRs1 = 6; exRs2 = 4;
    checkAtNeg("R2 mem forward A");

    // R3: write-back writer matches operand B
    nextCycle(); wbRegWrite = 1; wbRd = 5; exRs2 = 5; exRs1 = 9;
    checkAtNeg("R3 wb forward B");

    // R4: both stages write the same register
    nextCycle(); memRegWrite = 1; wbRegWrite = 1; memRd = 7; wbRd = 7; exRs1 = 7; exRs2 = 7;
    checkAtNeg("R4 mem beats wb");

    // R5: register zero never forwards
    nextCycle(); memRegWrite = 1; wbRegWrite = 1; memRd = 0; wbRd = 0; exRs1 = 0; exRs2 = 0;
    memMemToReg = 1;
    checkAtNeg("R5 zero register");

    // R6: memory stage not writing, write-back writes -> WB
    nextCycle(); memRegWrite = 0; memMemToReg = 1; memRd = 3; wbRegWrite = 1; wbRd = 3; exRs1 = 3;
    checkAtNeg("R6 mem regWrite clear");
    nextCycle(); memRd = 3; wbRd = 3; exRs1 = 3; exRs2 = 3; memBranch = 1; wbJump = 1;
    checkAtNeg("R6 both regWrite clear");

    // R7: execute-stage flags do not matter
    for (int f = 0; f < 32; f++) begin
      nextCycle();
      memRegWrite = 1; memRd = 4; wbRegWrite = 1; wbRd = 2; memMemToReg = 1;
      exRs1 = 4; exRs2 = 2; exRd = W'(f);
      {exJump, exBranch, exMemWrite, exMemToReg, exRegWrite} = 5'(f);
      checkAtNeg("R7 ex flags ignored");
    end

    // R8: load in memory stage feeding operand B
    nextCycle(); memMemToReg = 1; memRegWrite = 1; memRd = 3; exRs2 = 3; exRs1 = 8;
    checkAtNeg("R8 load-use on B");

    // R9: loads that must not flag
    nextCycle(); memMemToReg = 1; memRegWrite = 0; memRd = 3; exRs1 = 3;
    checkAtNeg("R9 load without regWrite");
    nextCycle(); wbMemToReg = 1; wbRegWrite = 1; wbRd = 3; exRs1 = 3;
    checkAtNeg("R9 load in write-back");
    nextCycle(); memMemToReg = 1; memRegWrite = 1; memRd = 5; exRs1 = 1; exRs2 = 2;
    checkAtNeg("R9 load no match");

    // R10: outputs settle mid-cycle without a clock edge
    nextCycle(); memRegWrite = 1; memRd = 9; exRs1 = 9;
    #1 compareNow("R10 first settle");
    wbRegWrite = 1; wbRd = 11; exRs2 = 11; memMemToReg = 1;
    #1 compareNow("R10 second settle");

    // randomized sweep over a narrow register range
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      #1;
      exRs1 = W'($urandom_range(0, 3)); exRs2 = W'($urandom_range(0, 3));
      exRd = W'($urandom_range(0, 3));
      memRd = W'($urandom_range(0, 3)); wbRd = W'($urandom_range(0, 3));
      memRs1 = W'($urandom); memRs2 = W'($urandom); wbRs1 = W'($urandom); wbRs2 = W'($urandom);
      {exMemToReg, exRegWrite, exMemWrite, exBranch, exJump} = 5'($urandom);
      {memMemToReg, memRegWrite, memMemWrite, memBranch, memJump} = 5'($urandom);
      {wbMemToReg, wbRegWrite, wbMemWrite, wbBranch, wbJump} = 5'($urandom);
      checkAtNeg("R2/R3/R4/R8 sweep");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule